// File: doc/BRIEF.md
# Sparse-Window Host-to-PCI Address Decoder

This block sits on the processor side of a host-to-PCI bridge. It accepts one processor load or store at a time, aimed at one of three address windows: sparse memory, sparse I/O or dense memory. It turns that access into a single PCI-side cycle request. The request carries a PCI address, a memory/I/O flag, active-low byte enables and write data already steered into the correct byte lanes. The PCI side returns a completion, and the block passes it back to the processor as a one-cycle response.

In the sparse windows the processor offset is five bits "wider" than the PCI address. Offset bits [4:3] carry the transfer size, and the offset shifted right by five is the PCI address. Sparse memory reaches only the low 27 PCI address bits directly. The top five bits come from an extension register, which is loaded through a small CSR write port. Dense memory passes the offset straight through. It only takes naturally aligned longword or 64-bit accesses. Any access the block cannot express on PCI is answered with an error and produces no PCI cycle.

Top module: `pci_sparse_decode`

## Requirements
- R1: Window select uses host address bits [33:29]. The sparse memory window is bits [33:32]=10, dense memory is bits [33:32]=11, and sparse I/O is bits [33:29]=01110. Any other region, including interrupt-acknowledge and configuration space, gets an error response and no PCI cycle.
- R2: A sparse memory access issues a memory cycle (p_io=0). Its address is {ext[4:0], h_addr[31:5]}.
- R3: A sparse I/O access issues an I/O cycle (p_io=1) with address {8'h00, h_addr[28:5]}. The extension register is never used for it.
- R4: Sparse size code h_addr[4:3] selects the transfer: 00 is a byte, 01 is a 16-bit word, 11 is a longword. Code 10 gets an error response.
- R5: p_be_n is active low, with bit i covering data bits [8i+7:8i]. With L=p_addr[1:0], a byte clears bit L, a word clears bits L and L+1, and a longword or dense access clears all four.
- R6: Sparse write data arrives right-justified in h_wdata and leaves shifted left by 8*L. Dense write data passes unchanged.
- R7: A word with L=3, or a sparse longword with L not equal to 0, gets an error response and no PCI cycle.
- R8: A dense access issues a memory cycle at p_addr=h_addr[31:0]. When h_wide=0 it must have h_addr[1:0]=00. When h_wide=1 (64-bit) it must have h_addr[2:0]=000, and p_wide is set. A misaligned dense access, or h_wide=1 on a sparse window, gets an error response.
- R9: The extension register clears to 0 on reset and loads csr_wdata[31:27] when csr_we is high. A request accepted in the same cycle as a CSR write uses the new value.
- R10: h_ready is high only when no transaction is in flight. p_valid rises one cycle after acceptance and holds with stable fields until p_ready. The response is a one-cycle rsp_valid pulse. It comes one cycle after p_rsp_valid and carries p_rdata unshifted, or it comes one cycle after acceptance with rsp_err=1 for a rejected access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_valid | input | 1 | Processor request valid |
| h_ready | output | 1 | Block can accept a request |
| h_addr | input | 34 | Processor physical address |
| h_write | input | 1 | 1 = store, 0 = load |
| h_wide | input | 1 | 64-bit dense access |
| h_wdata | input | 32 | Right-justified store data |
| rsp_valid | output | 1 | Response pulse |
| rsp_err | output | 1 | Access rejected |
| rsp_rdata | output | 32 | Load data, in the PCI lane |
| csr_we | input | 1 | Extension register write strobe |
| csr_wdata | input | 32 | Extension value, bits [31:27] used |
| p_valid | output | 1 | PCI cycle request valid |
| p_ready | input | 1 | PCI side takes the request |
| p_addr | output | 32 | PCI address |
| p_io | output | 1 | 1 = I/O cycle, 0 = memory cycle |
| p_write | output | 1 | 1 = write cycle |
| p_wide | output | 1 | 64-bit dense transfer |
| p_be_n | output | 4 | Active-low byte enables |
| p_wdata | output | 32 | Lane-steered write data |
| p_rsp_valid | input | 1 | PCI completion |
| p_rdata | input | 32 | PCI read data |

## Verification
The bench aims at the lane edges. A word in lane 2 must pass and a word in lane 3 must fail. A longword in any lane other than 0 must fail. A design with an off-by-one in the span test would either emit a cycle that wraps past byte 3 or refuse a legal word. A CSR write in the very cycle of a request checks forwarding: a design without it would put the stale upper bits on the PCI address. I/O accesses made while the extension register is non-zero would expose a design that wrongly merges it into I/O addresses. Stalled p_ready and recognisable read patterns show whether request fields drift during a stall and whether read data gets shifted on the way back.

// File: rtl/psd_pkg.sv
package psd_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_WORD = 2'b01,
      SZ_BAD  = 2'b10,
      SZ_LONG = 2'b11
   } psd_size_e;

   typedef enum logic [1:0] {
      WIN_NONE,
      WIN_SMEM,
      WIN_SIO,
      WIN_DENSE
   } psd_win_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ISSUE,
      ST_WAIT,
      ST_RESP
   } psd_state_e;

   localparam int SPARSE_SHIFT = 5;
endpackage

// File: rtl/psd_ext_reg.sv
module psd_ext_reg #(
   parameter int DATA_W = 32,
   parameter int EXT_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [EXT_W-1:0]  ext_eff
);
   logic [EXT_W-1:0] ext_q;
   logic [EXT_W-1:0] new_val;

   assign new_val = wdata[DATA_W-1 -: EXT_W];

   always_ff @(posedge clk) begin
      if (!rst_n)   ext_q <= '0;
      else if (we)  ext_q <= new_val;
   end

   // forward a same-cycle write so the accepted request sees it
   assign ext_eff = we ? new_val : ext_q;

   AST_EXT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(ext_q)); // R9
endmodule

// File: rtl/psd_window.sv
module psd_window
   import psd_pkg::*;
#(
   parameter int PCI_AW = 32,
   parameter int EXT_W  = 5,
   parameter int IO_AW  = 24
) (
   input  logic [PCI_AW+1:0] addr,
   input  logic              wide,
   input  logic [EXT_W-1:0]  ext,
   output psd_win_e          win,
   output psd_size_e         size,
   output logic [PCI_AW-1:0] pci_addr,
   output logic              bad
);
   localparam int HAW     = PCI_AW + 2;
   localparam int REG_LSB = PCI_AW - 3;
   localparam int REG_W   = HAW - REG_LSB;
   localparam logic [REG_W-1:0] IO_REGION = REG_W'(5'b01110);

   logic [PCI_AW-1:0] off;
   logic [1:0]        top2;

   assign off  = addr[PCI_AW-1:0];
   assign top2 = addr[HAW-1 -: 2];

   always_comb begin
      if (top2 == 2'b10)                            win = WIN_SMEM;
      else if (top2 == 2'b11)                       win = WIN_DENSE;
      else if (addr[HAW-1:REG_LSB] == IO_REGION)    win = WIN_SIO;
      else                                          win = WIN_NONE;
   end

   always_comb begin
      size     = SZ_LONG;
      pci_addr = off;
      bad      = 1'b0;
      unique case (win)
         WIN_SMEM: begin
            size     = psd_size_e'(off[4:3]);
            pci_addr = {ext, off[PCI_AW-1:SPARSE_SHIFT]};
            bad      = wide || (size == SZ_BAD);
         end
         WIN_SIO: begin
            size     = psd_size_e'(off[4:3]);
            pci_addr = {{(PCI_AW-IO_AW){1'b0}}, off[SPARSE_SHIFT +: IO_AW]};
            bad      = wide || (size == SZ_BAD);
         end
         WIN_DENSE: begin
            bad = wide ? (off[2:0] != 3'b000) : (off[1:0] != 2'b00);
         end
         default: bad = 1'b1;
      endcase
   end
endmodule

// File: rtl/psd_lanes.sv
module psd_lanes
   import psd_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  psd_size_e                       size,
   input  logic [$clog2(DATA_W/8)-1:0]     lane,
   input  logic [DATA_W-1:0]               wdata_in,
   output logic [DATA_W/8-1:0]             be_n,
   output logic [DATA_W-1:0]               wdata_out,
   output logic                            misalign
);
   localparam int LANES = DATA_W / 8;
   localparam int LW    = $clog2(LANES);
   localparam int CW    = LW + 2;

   logic [CW-1:0] nb;
   logic [CW-1:0] lane_x;
   logic [CW-1:0] span_end;

   always_comb begin
      unique case (size)
         SZ_BYTE: nb = CW'(1);
         SZ_WORD: nb = CW'(2);
         SZ_LONG: nb = CW'(LANES);
         default: nb = '0;
      endcase
   end

   assign lane_x   = CW'(lane);
   assign span_end = lane_x + nb;
   assign misalign = span_end > CW'(LANES);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign be_n[i] = !((CW'(i) >= lane_x) && (CW'(i) < span_end));
   end

   assign wdata_out = wdata_in << {lane, 3'b000};
endmodule

// File: rtl/pci_sparse_decode.sv
module pci_sparse_decode
   import psd_pkg::*;
#(
   parameter int PCI_AW = 32,
   parameter int DATA_W = 32,
   parameter int EXT_W  = 5,
   parameter int IO_AW  = 24
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  h_valid,
   output logic                  h_ready,
   input  logic [PCI_AW+1:0]     h_addr,
   input  logic                  h_write,
   input  logic                  h_wide,
   input  logic [DATA_W-1:0]     h_wdata,
   output logic                  rsp_valid,
   output logic                  rsp_err,
   output logic [DATA_W-1:0]     rsp_rdata,
   input  logic                  csr_we,
   input  logic [DATA_W-1:0]     csr_wdata,
   output logic                  p_valid,
   input  logic                  p_ready,
   output logic [PCI_AW-1:0]     p_addr,
   output logic                  p_io,
   output logic                  p_write,
   output logic                  p_wide,
   output logic [DATA_W/8-1:0]   p_be_n,
   output logic [DATA_W-1:0]     p_wdata,
   input  logic                  p_rsp_valid,
   input  logic [DATA_W-1:0]     p_rdata
);
   localparam int LANES = DATA_W / 8;
   localparam int LW    = $clog2(LANES);

   if (DATA_W != 32) begin : g_bad_dw
      $error("pci_sparse_decode: size codes assume a 32-bit data path");
   end
   if (EXT_W != SPARSE_SHIFT) begin : g_bad_ext
      $error("pci_sparse_decode: EXT_W must equal the sparse shift");
   end
   if (SPARSE_SHIFT + IO_AW > PCI_AW - 3) begin : g_bad_io
      $error("pci_sparse_decode: I/O address does not fit its window");
   end

   psd_state_e        state;
   logic [EXT_W-1:0]  ext_eff;
   psd_win_e          win;
   psd_size_e         size;
   logic [PCI_AW-1:0] dec_addr;
   logic              dec_bad;
   logic [LANES-1:0]  dec_be_n;
   logic [DATA_W-1:0] dec_wdata;
   logic              misalign;
   logic              accept;
   logic              reject;
   logic              err_q;

   psd_ext_reg #(.DATA_W(DATA_W), .EXT_W(EXT_W)) u_ext (
      .clk(clk), .rst_n(rst_n), .we(csr_we), .wdata(csr_wdata), .ext_eff(ext_eff)
   );

   psd_window #(.PCI_AW(PCI_AW), .EXT_W(EXT_W), .IO_AW(IO_AW)) u_win (
      .addr(h_addr), .wide(h_wide), .ext(ext_eff),
      .win(win), .size(size), .pci_addr(dec_addr), .bad(dec_bad)
   );

   psd_lanes #(.DATA_W(DATA_W)) u_lanes (
      .size(size), .lane(dec_addr[LW-1:0]), .wdata_in(h_wdata),
      .be_n(dec_be_n), .wdata_out(dec_wdata), .misalign(misalign)
   );

   assign h_ready = (state == ST_IDLE);
   assign accept  = h_valid && h_ready;
   assign reject  = dec_bad || misalign;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         err_q     <= 1'b0;
         p_addr    <= '0;
         p_io      <= 1'b0;
         p_write   <= 1'b0;
         p_wide    <= 1'b0;
         p_be_n    <= '1;
         p_wdata   <= '0;
         rsp_rdata <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (accept) begin
               err_q     <= reject;
               p_addr    <= dec_addr;
               p_io      <= (win == WIN_SIO);
               p_write   <= h_write;
               p_wide    <= h_wide;
               p_be_n    <= dec_be_n;
               p_wdata   <= dec_wdata;
               rsp_rdata <= '0;
               state     <= reject ? ST_RESP : ST_ISSUE;
            end
            ST_ISSUE: if (p_ready) state <= ST_WAIT;
            ST_WAIT: if (p_rsp_valid) begin
               rsp_rdata <= p_rdata;
               state     <= ST_RESP;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign p_valid   = (state == ST_ISSUE);
   assign rsp_valid = (state == ST_RESP);
   assign rsp_err   = rsp_valid && err_q;

   AST_REJECT_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && reject) |=> (!p_valid && rsp_valid && rsp_err)); // R7
   AST_PVALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (p_valid && !p_ready) |=> (p_valid && $stable(p_addr) && $stable(p_be_n) && $stable(p_wdata))); // R10
   AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid); // R10
   AST_BE_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
      p_valid |-> ($countones(~p_be_n) == 1 || $countones(~p_be_n) == 2 || $countones(~p_be_n) == LANES)); // R5
   AST_IO_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
      (p_valid && p_io) |-> (p_addr[PCI_AW-1:IO_AW] == '0)); // R3
   AST_WIDE_DENSE: assert property (@(posedge clk) disable iff (!rst_n)
      (p_valid && p_wide) |-> (!p_io && p_addr[2:0] == 3'b000)); // R8
endmodule

// File: tb/tb_pci_sparse_decode.sv
`timescale 1ns/1ps
module tb_pci_sparse_decode;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        h_valid = 1'b0, h_write = 1'b0, h_wide = 1'b0;
   logic [33:0] h_addr = '0;
   logic [31:0] h_wdata = '0;
   logic        h_ready, rsp_valid, rsp_err;
   logic [31:0] rsp_rdata;
   logic        csr_we = 1'b0;
   logic [31:0] csr_wdata = '0;
   logic        p_valid, p_io, p_write, p_wide;
   logic        p_ready = 1'b0, p_rsp_valid = 1'b0;
   logic [31:0] p_addr, p_wdata, p_rdata = '0;
   logic [3:0]  p_be_n;

   int n_chk = 0, n_fail = 0;
   bit done = 0;
   int ext_m = 0;
   int pat = 32'h1357_9BDF;

   always #2 clk = ~clk;

   pci_sparse_decode dut (
      .clk(clk), .rst_n(rst_n), .h_valid(h_valid), .h_ready(h_ready), .h_addr(h_addr),
      .h_write(h_write), .h_wide(h_wide), .h_wdata(h_wdata), .rsp_valid(rsp_valid),
      .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .csr_we(csr_we), .csr_wdata(csr_wdata),
      .p_valid(p_valid), .p_ready(p_ready), .p_addr(p_addr), .p_io(p_io), .p_write(p_write),
      .p_wide(p_wide), .p_be_n(p_be_n), .p_wdata(p_wdata), .p_rsp_valid(p_rsp_valid),
      .p_rdata(p_rdata)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   // behavioural reference for one access
   task automatic model(input longint a, input bit wide, input longint wd,
                        output bit err, output longint pa, output bit io,
                        output int be_n, output longint pwd);
      longint off = a & 64'hFFFF_FFFF;
      int sz, nb, lane, be;
      err = 0; io = 0; pa = 0; be_n = 0; pwd = wd;
      if ((a >> 32) == 3) begin
         pa = off;
         if (wide ? (off % 8 != 0) : (off % 4 != 0)) err = 1;
      end else if ((a >> 32) == 2 || (a >> 29) == 14) begin
         io = ((a >> 32) != 2);
         pa = io ? ((off >> 5) & 64'hFF_FFFF) : ((longint'(ext_m) << 27) | (off >> 5));
         sz = int'((off >> 3) & 3);
         nb = (sz == 0) ? 1 : (sz == 1) ? 2 : (sz == 3) ? 4 : 0;
         lane = int'(pa & 3);
         if (nb == 0 || lane + nb > 4 || wide) err = 1;
         be = 0;
         for (int k = 0; k < nb; k++) be = be | (1 << (lane + k));
         be_n = ~be & 4'hF;
         pwd = (wd << (8 * lane)) & 64'hFFFF_FFFF;
      end else begin
         err = 1;
      end
   endtask

   task automatic txn(input string tag, input longint a, input bit wr, input bit wide,
                      input longint wd, input bit csr, input longint cv, input int stall);
      bit e_err, e_io; longint e_pa, e_wd; int e_be;
      if (csr) ext_m = int'((cv >> 27) & 5'h1F);
      model(a, wide, wd, e_err, e_pa, e_io, e_be, e_wd);
      @(negedge clk);
      chk(h_ready == 1'b1, {tag, " h_ready idle R10"}, h_ready, 1);
      h_valid = 1; h_addr = a[33:0]; h_write = wr; h_wide = wide; h_wdata = wd[31:0];
      csr_we = csr; csr_wdata = cv[31:0];
      @(negedge clk);
      h_valid = 0; csr_we = 0;
      if (e_err) begin
         chk(p_valid == 1'b0, {tag, " no cycle on reject"}, p_valid, 0);
         chk(rsp_valid && rsp_err, {tag, " error response"}, {rsp_valid, rsp_err}, 3);
      end else begin
         for (int s = 0; s < stall; s++) begin
            chk(p_valid == 1'b1, {tag, " p_valid held R10"}, p_valid, 1);
            @(negedge clk);
         end
         chk(p_valid == 1'b1, {tag, " p_valid"}, p_valid, 1);
         chk(p_addr == e_pa[31:0], {tag, " p_addr"}, p_addr, e_pa);
         chk(p_io == e_io, {tag, " p_io"}, p_io, e_io);
         chk(p_be_n == e_be[3:0], {tag, " p_be_n"}, p_be_n, e_be);
         chk(p_wide == wide, {tag, " p_wide"}, p_wide, wide);
         if (wr) chk(p_wdata == e_wd[31:0], {tag, " p_wdata"}, p_wdata, e_wd);
         p_ready = 1;
         @(negedge clk);
         p_ready = 0; p_rsp_valid = 1; p_rdata = pat;
         chk(!h_ready && !p_valid, {tag, " busy one outstanding R10"}, {h_ready, p_valid}, 0);
         @(negedge clk);
         p_rsp_valid = 0;
         chk(rsp_valid && !rsp_err, {tag, " ok response R10"}, {rsp_valid, rsp_err}, 2);
         chk(rsp_rdata == pat, {tag, " read lane unshifted R10"}, rsp_rdata, pat);
         pat = pat * 5 + 32'h0101_0101;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1;
      @(negedge clk);
      chk(h_ready && !p_valid && !rsp_valid, "reset state R10", {h_ready, p_valid, rsp_valid}, 4);

      // sparse memory, byte/word/long, lanes (R2 R4 R5 R6)
      txn("R2 byte read lane3",  34'h2_0000_0000 + (34'h123457 << 5) + (0 << 3), 0, 0, 0, 0, 0, 0);
      txn("R6 byte write lane1", 34'h2_0000_0000 + (34'h000101 << 5) + (0 << 3), 1, 0, 'hA5, 0, 0, 2);
      txn("R6 word write lane2", 34'h2_0000_0000 + (34'h000202 << 5) + (1 << 3), 1, 0, 'hBEEF, 0, 0, 0);
      txn("R5 word lane0",       34'h2_0000_0000 + (34'h000200 << 5) + (1 << 3), 1, 0, 'h1234, 0, 0, 1);
      txn("R4 long lane0",       34'h2_0000_0000 + (34'h7FFFFFC << 5) + (3 << 3), 1, 0, 'hCAFE_F00D, 0, 0, 0);
      // alignment and size errors (R7 R4)
      txn("R7 word lane3",       34'h2_0000_0000 + (34'h000203 << 5) + (1 << 3), 1, 0, 'h55, 0, 0, 0);
      txn("R7 long lane1",       34'h2_0000_0000 + (34'h000201 << 5) + (3 << 3), 1, 0, 'h55, 0, 0, 0);
      txn("R4 size code 10",     34'h2_0000_0000 + (34'h000200 << 5) + (2 << 3), 0, 0, 0, 0, 0, 0);
      // extension register (R9)
      @(negedge clk); csr_we = 1; csr_wdata = 32'hD800_0000; ext_m = 5'h1B;
      @(negedge clk); csr_we = 0;
      txn("R9 ext applied",      34'h2_0000_0000 + (34'h0ABCDE << 5), 0, 0, 0, 0, 0, 0);
      txn("R9 same-cycle write", 34'h2_0000_0000 + (34'h000010 << 5), 0, 0, 0, 1, 'h0800_0000, 0);
      // sparse I/O ignores extension (R3)
      txn("R3 io byte",          34'h1_C000_0000 + (34'h3F8 << 5), 1, 0, 'h7E, 0, 0, 0);
      txn("R3 io top long",      34'h1_C000_0000 + (34'hFFFFFC << 5) + (3 << 3), 0, 0, 0, 0, 0, 0);
      // dense (R8)
      txn("R8 dense long",       34'h3_1234_5670, 1, 0, 'h8765_4321, 0, 0, 0);
      txn("R8 dense wide",       34'h3_0000_1008, 0, 1, 0, 0, 0, 1);
      txn("R8 dense misaligned", 34'h3_0000_0002, 0, 0, 0, 0, 0, 0);
      txn("R8 wide misaligned",  34'h3_0000_0004, 0, 1, 0, 0, 0, 0);
      txn("R8 sparse wide",      34'h2_0000_0000, 0, 1, 0, 0, 0, 0);
      // other regions (R1)
      txn("R1 iack region",      34'h1_A000_0000, 0, 0, 0, 0, 0, 0);
      txn("R1 config region",    34'h1_E000_0000, 0, 0, 0, 0, 0, 0);
      txn("R1 low region",       34'h0_0000_0100, 0, 0, 0, 0, 0, 0);
      txn("R1 sparse after errs",34'h2_0000_0000 + (34'h000021 << 5), 0, 0, 0, 0, 0, 0);
      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule